// File: doc/BRIEF.md
# Sample Capture Sequencer with Pre-Trigger Ring

This block sequences writes of probe samples into a dual-port sample store of `DEPTH` entries. It drives only the address and write-enable of the store's write port. The probe data goes straight from the probes to the store's data pin. A trigger pulse arrives from a separate trigger unit or from an external source. A small set of bus-side registers lets the controlling side do four things: set the capture mode and the count of samples to keep from before the trigger, start a capture, abort it, and read back the state and write pointer.

In single-shot mode the sequencer first fills a ring with the requested number of pre-trigger samples. It then keeps overwriting that ring on every cycle until the trigger arrives, and completes the window on every following cycle. Incremental mode records only on cycles where the trigger is high. Immediate mode records every cycle from the start and takes no notice of the trigger. When the store is full the sequencer parks in a done state. The reported write pointer then marks the oldest sample, so the reader can unroll the ring into time order.

Top module: `la_capture_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `wr_ptr_o` is 0, `mem_we_o` is 0, `mode_o` is 0 (single-shot) and `pos_o` is `DEPTH/2`.
- R2: A config write (`cfg_we_i`) takes effect only in the idle state and is ignored in every other state. Mode codes are 0 for single-shot, 1 for incremental and 2 for immediate; code 3 is stored as 0. A position above `DEPTH` is stored as `DEPTH`.
- R3: A start in idle clears the write pointer. `clear_i` returns the block to idle with `wr_ptr_o` = 0 on the next cycle, from any state, and takes priority over `start_i`.
- R4: In single-shot mode, let P = min(pos, DEPTH-1). Exactly P samples are written on consecutive cycles after the start, and `trig_i` is ignored during this fill. Writes then continue every cycle into the ring until a cycle with `trig_i` high. That cycle's sample lands at index P of the unrolled capture.
- R5: In single-shot mode, after the trigger sample a sample is written on every cycle until `DEPTH` samples have been kept. The block then enters the done state.
- R6: In incremental mode the block enters the capturing state on the cycle after start. It writes only on cycles with `trig_i` high, and is done after `DEPTH` writes.
- R7: In immediate mode the block writes on every cycle from the cycle after start, whatever `trig_i` does, and is done after `DEPTH` writes.
- R8: Each write goes to `mem_addr_o` = `wr_ptr_o`, and the pointer then advances by one modulo `DEPTH`. In the done state, capture index k sits at address (`wr_ptr_o` + k) mod `DEPTH`.
- R9: In the done state there are no writes, the pointer holds, and `start_i` is ignored until `clear_i`.
- R10: `state_o` codes are: 0 idle, 1 filling pre-trigger, 2 armed, 3 capturing, 4 done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Probe-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command (acted on in idle only) |
| clear_i | input | 1 | Abort/reset command, any state |
| trig_i | input | 1 | Trigger condition |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_mode_i | input | 2 | Capture mode code to write |
| cfg_pos_i | input | $clog2(DEPTH+1) | Pre-trigger sample count to write |
| mode_o | output | 2 | Stored mode |
| pos_o | output | $clog2(DEPTH+1) | Stored pre-trigger count |
| state_o | output | 3 | Sequencer state code |
| wr_ptr_o | output | $clog2(DEPTH) | Write pointer |
| mem_we_o | output | 1 | Sample store write enable |
| mem_addr_o | output | $clog2(DEPTH) | Sample store write address |

## Verification
A config write, start or clear presented before an edge shows up in `mode_o`, `pos_o`, `state_o` and `wr_ptr_o` right after that edge. The write enable follows the current state and `trig_i` within the same cycle, and the sample for that edge is stored at that edge. The bench changes inputs just after a falling edge and reads the outputs at the next falling edge, so every expected value falls one register stage after its stimulus. A model of the store records a cycle stamp at each edge where the enable is high. The driver queues the stamps the requirements predict, and the stored stamps are compared with them once the done state is reached and the ring has been unrolled from `wr_ptr_o`.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_ARMED = 3'd2,
    ST_RUN   = 3'd3,
    ST_DONE  = 3'd4
  } cap_state_e;

  typedef enum logic [1:0] {
    MD_SINGLE = 2'd0,
    MD_INCR   = 2'd1,
    MD_IMM    = 2'd2
  } cap_mode_e;
endpackage

// File: rtl/la_cap_cfg.sv
module la_cap_cfg
  import la_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    mode_i,
  input  logic [PW-1:0] pos_i,
  output cap_mode_e     mode_o,
  output logic [PW-1:0] pos_o
);
  logic [PW-1:0] pos_clamped;
  cap_mode_e     mode_dec;

  assign pos_clamped = (pos_i > PW'(DEPTH)) ? PW'(DEPTH) : pos_i;
  assign mode_dec    = (mode_i == 2'd3) ? MD_SINGLE : cap_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MD_SINGLE;
      pos_o  <= PW'(DEPTH / 2);
    end else if (wr_en_i) begin
      mode_o <= mode_dec;
      pos_o  <= pos_clamped;
    end
  end
endmodule

// File: rtl/la_cap_ptr.sv
module la_cap_ptr #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_nxt;

  generate
    if (DEPTH == (1 << AW)) begin : g_pow2
      assign ptr_nxt = ptr_o + AW'(1);
    end else begin : g_wrap
      assign ptr_nxt = (ptr_o == AW'(DEPTH - 1)) ? '0 : ptr_o + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (clr_i)  ptr_o <= '0;
    else if (adv_i)  ptr_o <= ptr_nxt;
  end
endmodule

// File: rtl/la_cap_fsm.sv
module la_cap_fsm
  import la_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          clear_i,
  input  logic          trig_i,
  input  cap_mode_e     mode_i,
  input  logic [PW-1:0] pos_i,
  output cap_state_e    state_o,
  output logic          we_o,
  output logic          restart_o
);
  cap_state_e    state_d;
  logic [PW-1:0] cnt_q, cnt_d, cnt_inc, pre;
  logic          full;

  // pos == DEPTH means trigger on last sample: DEPTH-1 samples before it
  assign pre       = (pos_i >= PW'(DEPTH)) ? PW'(DEPTH - 1) : pos_i;
  assign cnt_inc   = cnt_q + PW'(1);
  assign full      = (cnt_inc == PW'(DEPTH));
  assign restart_o = clear_i | ((state_o == ST_IDLE) & start_i);

  always_comb begin
    state_d = state_o;
    cnt_d   = cnt_q;
    we_o    = 1'b0;
    unique case (state_o)
      ST_IDLE: if (start_i) begin
        cnt_d = '0;
        if (mode_i != MD_SINGLE) state_d = ST_RUN;
        else if (pre == '0)      state_d = ST_ARMED;
        else                     state_d = ST_FILL;
      end
      ST_FILL: begin
        we_o  = 1'b1;
        cnt_d = cnt_inc;
        if (cnt_inc == pre) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        // ring keeps rolling; kept count only grows at the trigger
        we_o = 1'b1;
        if (trig_i) begin
          cnt_d   = cnt_inc;
          state_d = full ? ST_DONE : ST_RUN;
        end
      end
      ST_RUN: begin
        we_o = (mode_i == MD_INCR) ? trig_i : 1'b1;
        if (we_o) begin
          cnt_d = cnt_inc;
          if (full) state_d = ST_DONE;
        end
      end
      ST_DONE: ;
      default: state_d = ST_IDLE;
    endcase
    if (clear_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      we_o    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_o <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
  import la_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          clear_i,
  input  logic          trig_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_mode_i,
  input  logic [PW-1:0] cfg_pos_i,
  output logic [1:0]    mode_o,
  output logic [PW-1:0] pos_o,
  output logic [2:0]    state_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o
);
  cap_mode_e  mode;
  cap_state_e state;
  logic       we, restart;

  la_cap_cfg #(.DEPTH(DEPTH)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (cfg_we_i & (state == ST_IDLE)),
    .mode_i  (cfg_mode_i),
    .pos_i   (cfg_pos_i),
    .mode_o  (mode),
    .pos_o   (pos_o)
  );

  la_cap_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .clear_i   (clear_i),
    .trig_i    (trig_i),
    .mode_i    (mode),
    .pos_i     (pos_o),
    .state_o   (state),
    .we_o      (we),
    .restart_o (restart)
  );

  la_cap_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .adv_i  (we),
    .ptr_o  (wr_ptr_o)
  );

  assign mode_o     = mode;
  assign state_o    = state;
  assign mem_we_o   = we;
  assign mem_addr_o = wr_ptr_o;
endmodule

// File: rtl/la_capture_ctrl_chk.sv
module la_capture_ctrl_chk #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clear_i,
  input logic          trig_i,
  input logic [1:0]    mode_o,
  input logic [PW-1:0] pos_o,
  input logic [2:0]    state_o,
  input logic [AW-1:0] wr_ptr_o,
  input logic          mem_we_o
);
  // R3
  clear_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (state_o == 3'd0) && (wr_ptr_o == '0));
  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 3'd0) |=> $stable(mode_o) && $stable(pos_o));
  // R4
  fill_ignores_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1) && !clear_i |=> (state_o == 3'd1) || (state_o == 3'd2));
  // R6
  incr_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3) && (mode_o == 2'd1) && !clear_i |-> (mem_we_o == trig_i));
  // R7
  imm_every_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3) && (mode_o == 2'd2) && !clear_i |-> mem_we_o);
  // R8
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && !clear_i |=> int'(wr_ptr_o) == ((int'($past(wr_ptr_o)) + 1) % DEPTH));
  // R9
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4) && !clear_i |=> (state_o == 3'd4) && $stable(wr_ptr_o));
  // R10
  quiet_states_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0) || (state_o == 3'd4) |-> !mem_we_o);
endmodule

bind la_capture_ctrl la_capture_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clear_i  (clear_i),
  .trig_i   (trig_i),
  .mode_o   (mode_o),
  .pos_o    (pos_o),
  .state_o  (state_o),
  .wr_ptr_o (wr_ptr_o),
  .mem_we_o (mem_we_o)
);

// File: tb/tb_la_capture_ctrl.sv
module tb_la_capture_ctrl;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          start_i = 0, clear_i = 0, trig_i = 0, cfg_we_i = 0;
  logic [1:0]    cfg_mode_i = '0;
  logic [PW-1:0] cfg_pos_i = '0;
  logic [1:0]    mode_o;
  logic [PW-1:0] pos_o;
  logic [2:0]    state_o;
  logic [AW-1:0] wr_ptr_o, mem_addr_o;
  logic          mem_we_o;

  int checks = 0, errors = 0, cyc = 0, s, t;
  bit finished = 0;
  int mem [DEPTH];
  int exp_q [$];

  la_capture_ctrl #(.DEPTH(DEPTH)) dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  // store model: stamp = edge index
  always @(posedge clk_i) begin
    if (mem_we_o) mem[mem_addr_o] <= cyc;
    cyc <= cyc + 1;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk_i); endtask

  task automatic wait_state(int st);
    for (int i = 0; i < 200 && int'(state_o) != st; i++) tick();
  endtask

  task automatic push_run(int first, int n);
    for (int i = 0; i < n; i++) exp_q.push_back(first + i);
  endtask

  // monitor side: pop expected stamps against the unrolled ring
  task automatic drain(string req);
    for (int k = 0; k < DEPTH && exp_q.size() > 0; k++)
      chk(req, mem[(int'(wr_ptr_o) + k) % DEPTH], exp_q.pop_front());
  endtask

  task automatic cfg(int md, int ps);
    cfg_we_i = 1; cfg_mode_i = 2'(md); cfg_pos_i = PW'(ps);
    tick();
    cfg_we_i = 0;
  endtask

  task automatic do_clear();
    clear_i = 1; tick(); clear_i = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1;
    tick();
    // R1 reset values
    chk("R1 state", state_o, 0);
    chk("R1 ptr", wr_ptr_o, 0);
    chk("R1 we", mem_we_o, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 pos", pos_o, DEPTH / 2);

    // single-shot, default pos 8, delayed trigger with ring wrap
    start_i = 1; s = cyc; tick();
    start_i = 0; trig_i = 1;
    chk("R10 fill code", state_o, 1);
    tick(); chk("R4 trig ignored in fill", state_o, 1);
    tick(); chk("R4 trig ignored in fill", state_o, 1);
    trig_i = 0;
    wait_state(2);
    chk("R10 armed code", state_o, 2);
    cfg(2, 3);
    chk("R2 mode held", mode_o, 0);
    chk("R2 pos held", pos_o, DEPTH / 2);
    repeat (3) tick();
    trig_i = 1; t = cyc; tick(); trig_i = 0;
    chk("R10 run code", state_o, 3);
    wait_state(4);
    chk("R5 done", state_o, 4);
    chk("R4 trigger at index 8", mem[(int'(wr_ptr_o) + 8) % DEPTH], t);
    push_run(t - 8, DEPTH);
    drain("R5");

    // R9 start ignored in done
    s = int'(wr_ptr_o);
    start_i = 1; tick(); start_i = 0;
    chk("R9 state", state_o, 4);
    chk("R9 ptr", wr_ptr_o, s);
    tick(); chk("R9 no write", mem_we_o, 0);
    do_clear();
    chk("R3 idle", state_o, 0);
    chk("R3 ptr", wr_ptr_o, 0);

    // pos 0, trigger held from start
    cfg(0, 0);
    chk("R2 pos 0", pos_o, 0);
    start_i = 1; trig_i = 1; s = cyc; tick(); start_i = 0;
    chk("R4 pos0 armed", state_o, 2);
    wait_state(4); trig_i = 0;
    chk("R4 trigger at index 0", mem[wr_ptr_o], s + 1);
    chk("R8 ptr wrap", wr_ptr_o, 0);
    push_run(s + 1, DEPTH);
    drain("R8");
    do_clear();

    // pos above depth clamps; mode 3 stored as 0
    cfg(3, 20);
    chk("R2 pos clamp", pos_o, DEPTH);
    chk("R2 mode 3", mode_o, 0);
    start_i = 1; trig_i = 1; s = cyc; tick(); start_i = 0;
    wait_state(4); trig_i = 0;
    chk("R4 trigger last", mem[(int'(wr_ptr_o) + DEPTH - 1) % DEPTH], s + DEPTH);
    push_run(s + 1, DEPTH);
    drain("R4");
    do_clear();

    // incremental
    cfg(1, 4);
    chk("R2 mode incr", mode_o, 1);
    start_i = 1; tick(); start_i = 0;
    chk("R6 run after start", state_o, 3);
    for (int i = 0; i < 60 && state_o != 3'd4; i++) begin
      trig_i = (i % 3 == 0);
      if (trig_i) exp_q.push_back(cyc);
      tick();
    end
    trig_i = 0;
    chk("R6 done", state_o, 4);
    chk("R6 ptr", wr_ptr_o, 0);
    drain("R6");
    do_clear();

    // immediate, trigger never set
    cfg(2, 8);
    start_i = 1; s = cyc; tick(); start_i = 0;
    chk("R7 run after start", state_o, 3);
    wait_state(4);
    chk("R7 done", state_o, 4);
    push_run(s + 1, DEPTH);
    drain("R7");
    do_clear();

    // clear mid-capture beats a simultaneous start
    start_i = 1; tick(); start_i = 0;
    repeat (4) tick();
    chk("R7 ptr after 4", wr_ptr_o, 4);
    clear_i = 1; start_i = 1; tick(); clear_i = 0; start_i = 0;
    chk("R3 clear wins state", state_o, 0);
    chk("R3 clear wins ptr", wr_ptr_o, 0);
    tick();
    chk("R3 stays idle", state_o, 0);

    finish_run();
  end
endmodule